// File: doc/BRIEF.md
# Dual-Clause MDIO Management Master

This block is a register-driven management master for one MDC/MDIO pair. Software writes four small registers: a configuration word, a target address, a data word and an operation code. Writing the operation code launches one management frame on the wire. The start-of-frame field comes from the configuration word at the moment of launch, so clause 22 and clause 45 devices can share the bus and software picks the frame type per transaction. A clause 45 access takes two launches: an address frame, which carries the 16-bit register number as its payload, and then a read or write frame to the same PHY and device. If the address frame does not succeed, software does not issue the second one.

MDC is built from the core clock by a programmable divider. Each half period of MDC lasts (divider + 1) core cycles. MDC idles low. MDIO is released between frames and changes only on falling MDC edges. A busy flag covers the whole frame. When a read frame ends, the 16 bits sampled on rising MDC edges replace the data register.

The frame sequencer has five named states. `FR_IDLE` goes to `FR_PREAMBLE` on a launch if the preamble is enabled, and to `FR_HEADER` otherwise. `FR_PREAMBLE` holds for 32 one bits and then goes to `FR_HEADER`. `FR_HEADER` carries ST, OP, PHY address and register/device address, 14 bits in all, and then goes to `FR_TURN`. `FR_TURN` covers the 2 turnaround bits and then goes to `FR_PAYLOAD`. `FR_PAYLOAD` covers the 16 data bits and returns to `FR_IDLE` on the last falling MDC edge. Every state advances only on a falling MDC edge.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset and whenever no frame is running, `busy` is 0, `mdc` is 0 and `mdio_oe` is 0.
- R2: A register write with `reg_sel` = 3 (operation) while idle raises `busy` from the next cycle. `busy` then stays high for exactly N·2·(div+1) cycles, where N = 32 without preamble and N = 64 with preamble.
- R3: Each MDC half period lasts div+1 core cycles. `div` is configuration bits [15:8], which are latched when the frame starts.
- R4: The ST field is `01` when configuration bit 0 is 1 (clause 22) and `00` when it is 0 (clause 45). The choice is taken per frame.
- R5: When configuration bit 1 is set, the frame starts with 32 one bits. The frame is ST(2), OP(2), PHY(5), REG(5), TA(2), DATA(16), sent MSB first. OP is operation bits [1:0] as written. PHY is address bits [12:8] and REG is address bits [4:0].
- R6: For opcodes 0 (address) and 1 (write), the master drives the turnaround as `1` then `0`, and drives data register bits [15:0] as the payload.
- R7: For opcodes 2 and 3 (reads), `mdio_oe` is 0 through the turnaround and the payload. The 16 bits on `mdio_i` at rising MDC edges are written to the data register when the frame ends.
- R8: An operation write while `busy` is 1 is ignored. The running frame, and how long it lasts, do not change.
- R9: Address and write frames leave the data register holding its written value.
- R10: While a frame runs, `mdio_o` changes only on a falling MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 config, 1 address, 2 data, 3 operation |
| reg_wdata | input | 16 | Register write value |
| busy | output | 1 | High while a frame is in progress |
| data_reg | output | 16 | Data register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
`busy` rises on the first cycle after the operation write and falls exactly N·2·(div+1) cycles later. The bench counts busy cycles on falling core-clock edges and compares that count with the computed value. Wire bits are captured one time unit after each rising MDC edge, when MDIO has settled for at least a half period. The bench PHY model changes `mdio_i` right after each rising MDC edge, so each read bit is stable for the whole MDC period before the master samples it. The data register is compared on the first idle cycle after `busy` falls, because read data is stored at the same edge that ends the frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;
    localparam int CNT_W     = $clog2(PRE_BITS);

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_PREAMBLE,
        FR_HEADER,
        FR_TURN,
        FR_PAYLOAD
    } frame_state_e;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_OP   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] st;
        logic [1:0] op;
        logic [4:0] phy;
        logic [4:0] regad;
    } frame_hdr_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             hit;

    assign hit       = run && (cnt_q == div);
    assign rise_tick = hit && !mdc_q;
    assign fall_tick = hit && mdc_q;
    assign mdc       = mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (hit) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: a toggle of MDC only ever follows a full half period of counting
    assert_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (mdc_q != $past(mdc_q))) |-> ($past(cnt_q) == $past(div)));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 pre_en,
    input  frame_hdr_t           hdr,
    input  logic [DATA_BITS-1:0] wdata,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 rd_done,
    output logic [DATA_BITS-1:0] rdata
);

    frame_state_e         state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [HDR_BITS-1:0]  hdr_sr;
    logic [DATA_BITS-1:0] data_sr;
    logic                 rd_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE:     if (start) state_d = pre_en ? FR_PREAMBLE : FR_HEADER;
            FR_PREAMBLE: if (fall_tick && cnt_q == CNT_W'(PRE_BITS-1)) state_d = FR_HEADER;
            FR_HEADER:   if (fall_tick && cnt_q == CNT_W'(HDR_BITS-1)) state_d = FR_TURN;
            FR_TURN:     if (fall_tick && cnt_q == CNT_W'(TA_BITS-1)) state_d = FR_PAYLOAD;
            FR_PAYLOAD:  if (fall_tick && cnt_q == CNT_W'(DATA_BITS-1)) state_d = FR_IDLE;
            default:     state_d = FR_IDLE;
        endcase
    end

    // state register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= '0;
            else if (fall_tick)     cnt_q <= cnt_q + 1'b1;
        end
    end

    // shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_sr  <= '0;
            data_sr <= '0;
            rd_q    <= 1'b0;
        end else if (state_q == FR_IDLE) begin
            if (start) begin
                hdr_sr  <= hdr;
                data_sr <= wdata;
                rd_q    <= hdr.op[1];
            end
        end else begin
            if (state_q == FR_HEADER && fall_tick)
                hdr_sr <= {hdr_sr[HDR_BITS-2:0], 1'b0};
            if (state_q == FR_PAYLOAD) begin
                if (rd_q && rise_tick)
                    data_sr <= {data_sr[DATA_BITS-2:0], mdio_i};
                else if (!rd_q && fall_tick)
                    data_sr <= {data_sr[DATA_BITS-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state_q)
            FR_IDLE: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
            FR_PREAMBLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            FR_HEADER: begin
                mdio_o  = hdr_sr[HDR_BITS-1];
                mdio_oe = 1'b1;
            end
            FR_TURN: begin
                mdio_o  = !rd_q && (cnt_q == '0);
                mdio_oe = !rd_q;
            end
            FR_PAYLOAD: begin
                mdio_o  = !rd_q && data_sr[DATA_BITS-1];
                mdio_oe = !rd_q;
            end
            default: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
    end

    assign busy    = (state_q != FR_IDLE);
    assign rd_done = rd_q && (state_q == FR_PAYLOAD) && (state_d == FR_IDLE);
    assign rdata   = data_sr;

    // R7: reads never drive the line after the header
    assert_read_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && (state_q == FR_TURN || state_q == FR_PAYLOAD)) |-> !mdio_oe);

    // R8: frame type stays fixed once a frame is under way
    assert_op_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_q));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    output logic        busy,
    output logic [15:0] data_reg,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    localparam int DIV_LSB = 8;

    logic             cfg_c22, cfg_pre;
    logic [DIV_W-1:0] cfg_div, div_q;
    logic [4:0]       addr_phy, addr_reg;
    logic [15:0]      data_q;
    logic             start, data_wr, last_rd;
    logic             rise_tick, fall_tick, rd_done;
    logic [15:0]      rdata;
    frame_hdr_t       hdr;

    assign start   = reg_wr && (reg_sel == SEL_OP) && !busy;
    assign data_wr = reg_wr && (reg_sel == SEL_DATA);

    assign hdr.st    = cfg_c22 ? 2'b01 : 2'b00;
    assign hdr.op    = reg_wdata[1:0];
    assign hdr.phy   = addr_phy;
    assign hdr.regad = addr_reg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_c22  <= 1'b1;
            cfg_pre  <= 1'b1;
            cfg_div  <= '0;
            div_q    <= '0;
            addr_phy <= '0;
            addr_reg <= '0;
            data_q   <= '0;
            last_rd  <= 1'b0;
        end else begin
            if (reg_wr && reg_sel == SEL_CFG) begin
                cfg_c22 <= reg_wdata[0];
                cfg_pre <= reg_wdata[1];
                cfg_div <= reg_wdata[DIV_LSB +: DIV_W];
            end
            if (reg_wr && reg_sel == SEL_ADDR) begin
                addr_reg <= reg_wdata[4:0];
                addr_phy <= reg_wdata[12:8];
            end
            if (rd_done)      data_q <= rdata;
            else if (data_wr) data_q <= reg_wdata;
            if (start) begin
                div_q   <= cfg_div;
                last_rd <= reg_wdata[1];
            end
        end
    end

    mdio_clk_div #(.DIV_W(DIV_W)) u_clk_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pre_en    (cfg_pre),
        .hdr       (hdr),
        .wdata     (data_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_done   (rd_done),
        .rdata     (rdata)
    );

    assign data_reg = data_q;

    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_OP && !busy) |=> busy);

    assert_data_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !last_rd && !$past(data_wr)) |-> $stable(data_q));

    assert_mdio_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> ($past(mdc) && !mdc));

endmodule

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic [15:0] data_reg;
    logic        mdio_i = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    // PHY model state
    logic        cap_o  [64];
    logic        cap_oe [64];
    int          nrise = 0;
    logic [15:0] phy_resp = 16'h0;
    int          cur_off = 0;

    always #4 clk = ~clk;

    mdio_mgmt_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .busy(busy), .data_reg(data_reg),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bench-side PHY: capture each bit at rising MDC, present next read bit
    initial begin
        forever begin
            @(posedge mdc);
            #1;
            if (nrise < 64) begin
                cap_o[nrise]  = mdio_o;
                cap_oe[nrise] = mdio_oe;
            end
            nrise++;
            begin
                int k;
                k = nrise - cur_off - 16;
                mdio_i = (k >= 0 && k < 16) ? phy_resp[15-k] : 1'b1;
            end
        end
    end

    task automatic wr_reg(input logic [1:0] sel, input logic [15:0] val);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run_txn(input bit c22, input bit pre, input int div,
                           input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] wd,
                           input logic [15:0] resp, input bit interfere);
        int n, cyc, bad, ta_bad;
        bit rd;
        n  = pre ? 64 : 32;
        rd = op[1];
        wr_reg(2'd0, {div[7:0], 6'b0, pre, c22});
        wr_reg(2'd1, {3'b0, phy, 3'b0, rg});
        wr_reg(2'd2, wd);
        phy_resp = resp;
        cur_off  = pre ? 32 : 0;
        nrise    = 0;
        mdio_i   = 1'b1;
        wr_reg(2'd3, {14'h0, op});
        chk(busy == 1'b1, "R2 busy after op write", busy, 1);
        cyc = 0;
        while (busy && cyc < 20000) begin
            cyc++;
            if (interfere && cyc == 5) begin
                reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = {14'h0, ~op};
            end else begin
                reg_wr = 1'b0;
            end
            @(negedge clk);
        end
        reg_wr = 1'b0;
        chk(cyc == n * 2 * (div + 1), interfere ? "R8 busy length" : "R2 R3 busy length",
            cyc, n * 2 * (div + 1));
        chk(nrise == n, "R5 bit count", nrise, n);
        bad = 0; ta_bad = 0;
        for (int i = 0; i < n; i++) begin
            bit eoe, ev;
            int f;
            f = i - cur_off;
            eoe = 1'b1; ev = 1'b1;
            if (f < 0)        ev = 1'b1;
            else if (f < 2)   ev = (f == 0) ? 1'b0 : c22;
            else if (f < 4)   ev = op[3-f];
            else if (f < 9)   ev = phy[8-f];
            else if (f < 14)  ev = rg[13-f];
            else if (f < 16) begin eoe = !rd; ev = !rd && (f == 14); end
            else             begin eoe = !rd; ev = !rd && wd[31-f]; end
            if (cap_oe[i] !== eoe || (eoe && cap_o[i] !== ev)) begin
                bad++;
                if (f >= 14 && f < 16) ta_bad++;
            end
        end
        chk(cap_o[cur_off] == 1'b0 && cap_o[cur_off+1] == c22, "R4 start field",
            {cap_o[cur_off], cap_o[cur_off+1]}, {1'b0, c22});
        chk(bad == 0, interfere ? "R8 frame unchanged" : "R5 frame bits", bad, 0);
        chk(ta_bad == 0, rd ? "R7 turnaround released" : "R6 turnaround 10", ta_bad, 0);
        if (rd) chk(data_reg == resp, "R7 read data", data_reg, resp);
        else    chk(data_reg == wd, "R9 data kept", data_reg, wd);
        chk(!mdc && !mdio_oe && !busy, "R1 idle after frame", {mdc, mdio_oe, busy}, 0);
    endtask

    initial begin
        #(8 * 190000);
        if (!done_flag) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mdc && !mdio_oe, "R1 reset state", {busy, mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mdc && !mdio_oe, "R1 idle after reset", {busy, mdc, mdio_oe}, 0);
        // sweep of start field, preamble, opcode and divider
        for (int d = 0; d < 2; d++)
            for (int c = 0; c < 2; c++)
                for (int p = 0; p < 2; p++)
                    for (int o = 0; o < 4; o++)
                        run_txn(c[0], p[0], d * 2, o[1:0], 5'(5'h13 + o + 3*c),
                                5'(5'h0A ^ (o*5 + p)), 16'(16'hA5C3 ^ (o * 16'h1111) ^ (d << 4)),
                                16'(16'h3C96 + o * 16'h0777 + c), 1'b0);
        // wider divider
        run_txn(1'b0, 1'b1, 5, 2'd3, 5'h1F, 5'h00, 16'h0001, 16'h8001, 1'b0);
        run_txn(1'b1, 1'b0, 5, 2'd1, 5'h00, 5'h1F, 16'hFFFE, 16'h0000, 1'b0);
        // operation writes while busy are ignored
        run_txn(1'b1, 1'b1, 1, 2'd1, 5'h05, 5'h11, 16'h5AA5, 16'h0F0F, 1'b1);
        run_txn(1'b0, 1'b0, 0, 2'd3, 5'h0C, 5'h03, 16'h1234, 16'hBEEF, 1'b1);
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule